// File: doc/BRIEF.md
# Gate Driver Fault and Interlock Controller

This block is the low-side decision logic in front of a seven-channel gate driver for a three-phase bridge. It takes three high/low command pairs, one extra low-side command for a boost or brake switch, an undervoltage indication with separate set and release flags, and per-path overcurrent flags from shunt comparators. It produces seven gated drive requests, a per-path fault record and one global error line for the host controller.

An optional cross-conduction guard can be switched on by the user. When it is on, a pair never drives both switches, a request for both gives neither, and a programmable dead time separates the turn-off of one switch from the turn-on of its partner. Overcurrent or undervoltage conditions override the guard and every command. An overcurrent fault latches until the host pulses a clear while all fault sources are quiet.

Top module: `gdrv_guard`

## Requirements
- R1: After reset all seven outputs, `loc_err` and `err_out` are low and undervoltage lockout is engaged, so outputs stay low whatever the commands until `uv_rel` is seen high.
- R2: With `ilk_en` low and no fault or lockout, each output follows its own command, including both switches of a pair at once.
- R3: All seven outputs have the same latency: each shows the command sampled at the previous rising clock edge.
- R4: With `ilk_en` high, a pair whose high and low commands are both high drives neither switch.
- R5: With `ilk_en` high, after one switch of a pair turns off, both stay off for exactly `dead_cnt`+1 cycles before the partner, if requested, turns on.
- R6: `uv_set` high turns every output off from the next edge and engages lockout; lockout ends only on an edge where `uv_rel` is high and `uv_set` is low (set wins), and outputs resume one edge after that. Lockout does not raise `err_out`.
- R7: A high bit of `oc_flag` (bits 0 to 2 are the three pairs, bit 3 the extra channel) sets the same bit of `loc_err` and raises `err_out` at the next edge, and every output is off from that edge.
- R8: `loc_err` and `err_out` stay set after `oc_flag` returns low, until a clear is accepted.
- R9: `clr` is ignored while any `oc_flag` bit, `uv_set` or lockout is active; otherwise it clears `loc_err` and `err_out` at the next edge, and outputs resume one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ilk_en | input | 1 | Cross-conduction guard enable |
| dead_cnt | input | DT_W | Dead-time length in cycles |
| hi_cmd | input | NPAIR | High-side commands |
| lo_cmd | input | NPAIR | Low-side commands |
| aux_cmd | input | 1 | Extra low-side channel command |
| uv_set | input | 1 | Undervoltage detected |
| uv_rel | input | 1 | Supply recovered |
| oc_flag | input | NPAIR+1 | Shunt overcurrent flags |
| clr | input | 1 | Fault clear request |
| hi_drv | output | NPAIR | Gated high-side drive |
| lo_drv | output | NPAIR | Gated low-side drive |
| aux_drv | output | 1 | Gated extra-channel drive |
| loc_err | output | NPAIR+1 | Latched per-path faults |
| err_out | output | 1 | Global error to controller |

## Verification
The pass-through path is driven with patterns that include both switches of a pair on, so it is distinguished from the guarded path, and all seven commands change in one cycle to show equal latency. The guard is tried with a simultaneous request and with a high-to-low swap at two dead-time values, the exact cycle of the partner's turn-on separating a short, correct or long gap. Faults are raised on a pair and on the extra channel, and clears are issued during an active flag, during lockout and when quiet, which tells a latched record apart from a level-following one and an accepted clear from an ignored one; undervoltage set and release are raised together to show which wins.

// File: rtl/gdrv_guard.sv
module gdrv_guard #(
  parameter int NPAIR = 3,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ilk_en,
  input  logic [DT_W-1:0]  dead_cnt,
  input  logic [NPAIR-1:0] hi_cmd,
  input  logic [NPAIR-1:0] lo_cmd,
  input  logic             aux_cmd,
  input  logic             uv_set,
  input  logic             uv_rel,
  input  logic [NPAIR:0]   oc_flag,
  input  logic             clr,
  output logic [NPAIR-1:0] hi_drv,
  output logic [NPAIR-1:0] lo_drv,
  output logic             aux_drv,
  output logic [NPAIR:0]   loc_err,
  output logic             err_out
);

  logic             uv_lock;
  logic [NPAIR-1:0] nh, nl;

  wire oc_any = |oc_flag;
  wire blk    = uv_set | uv_lock | err_out | oc_any;
  wire clr_ok = clr & ~oc_any & ~uv_lock & ~uv_set;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    logic [DT_W-1:0] cnt;
    wire both = hi_cmd[i] & lo_cmd[i];
    wire idle = (cnt == '0);
    wire wh   = hi_cmd[i] & ~both;
    wire wl   = lo_cmd[i] & ~both;

    assign nh[i] = ~blk & (ilk_en ? (wh & ~lo_drv[i] & idle) : hi_cmd[i]);
    assign nl[i] = ~blk & (ilk_en ? (wl & ~hi_drv[i] & idle) : lo_cmd[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt <= '0;
      else if ((hi_drv[i] & ~nh[i]) | (lo_drv[i] & ~nl[i]))
        cnt <= dead_cnt;
      else if (!idle)
        cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_drv  <= '0;
      lo_drv  <= '0;
      aux_drv <= 1'b0;
    end else begin
      hi_drv  <= nh;
      lo_drv  <= nl;
      aux_drv <= ~blk & aux_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      uv_lock <= 1'b1;
    else if (uv_set)
      uv_lock <= 1'b1;
    else if (uv_rel)
      uv_lock <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_err <= '0;
      err_out <= 1'b0;
    end else if (clr_ok) begin
      loc_err <= '0;
      err_out <= 1'b0;
    end else begin
      loc_err <= loc_err | oc_flag;
      err_out <= err_out | oc_any;
    end
  end

endmodule

// File: rtl/gdrv_guard_chk.sv
module gdrv_guard_chk #(
  parameter int NPAIR = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ilk_en,
  input logic             uv_set,
  input logic [NPAIR:0]   oc_flag,
  input logic             clr,
  input logic [NPAIR-1:0] hi_drv,
  input logic [NPAIR-1:0] lo_drv,
  input logic             aux_drv,
  input logic [NPAIR:0]   loc_err,
  input logic             err_out
);

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    ilk_en |=> ((hi_drv & lo_drv) == '0)); // R4

  AST_UV_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv_set |=> (hi_drv == '0 && lo_drv == '0 && !aux_drv)); // R6

  AST_OC_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (|oc_flag) |=> (err_out && hi_drv == '0 && lo_drv == '0 && !aux_drv)); // R7

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_out && !clr) |=> err_out); // R8

  AST_LOC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((loc_err & $past(loc_err)) == $past(loc_err))); // R8

  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_out && (|oc_flag)) |=> err_out); // R9

endmodule

bind gdrv_guard gdrv_guard_chk #(.NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ilk_en(ilk_en), .uv_set(uv_set),
  .oc_flag(oc_flag), .clr(clr), .hi_drv(hi_drv), .lo_drv(lo_drv),
  .aux_drv(aux_drv), .loc_err(loc_err), .err_out(err_out)
);

// File: tb/sim_gdrv_guard.sv
`timescale 1ns/1ps
module sim_gdrv_guard;
  logic       clk = 0, rst_n = 0;
  logic       ilk_en = 0, aux_cmd = 0, uv_set = 0, uv_rel = 0, clr = 0;
  logic [7:0] dead_cnt = 0;
  logic [2:0] hi_cmd = 0, lo_cmd = 0;
  logic [3:0] oc_flag = 0;
  logic [2:0] hi_drv, lo_drv;
  logic       aux_drv, err_out;
  logic [3:0] loc_err;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  gdrv_guard u0 (
    .clk(clk), .rst_n(rst_n), .ilk_en(ilk_en), .dead_cnt(dead_cnt),
    .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .aux_cmd(aux_cmd), .uv_set(uv_set),
    .uv_rel(uv_rel), .oc_flag(oc_flag), .clr(clr), .hi_drv(hi_drv),
    .lo_drv(lo_drv), .aux_drv(aux_drv), .loc_err(loc_err), .err_out(err_out)
  );

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {aux_drv, lo_drv, hi_drv};
  endfunction

  task automatic t_reset();
    cyc(2); rst_n = 1;
    hi_cmd = 3'b111; aux_cmd = 1;
    cyc(2);
    chk("R1 outputs held off in lockout", outs(), 7'd0);
    chk("R1 error low", {loc_err, err_out}, 5'd0);
    uv_rel = 1; cyc(); uv_rel = 0;
    chk("R1 off on release edge", outs(), 7'd0);
    cyc();
    chk("R1 outputs after release", outs(), {1'b1, 3'b000, 3'b111});
  endtask

  task automatic t_pass();
    ilk_en = 0;
    hi_cmd = 0; lo_cmd = 0; aux_cmd = 0; cyc();
    chk("R2 all off", outs(), 7'd0);
    hi_cmd = 3'b101; lo_cmd = 3'b111; aux_cmd = 1;
    chk("R3 old value before edge", outs(), 7'd0);
    cyc();
    chk("R3 all seven after one edge", outs(), {1'b1, 3'b111, 3'b101});
    chk("R2 both of pair on when guard off", {hi_drv[0], lo_drv[0]}, 2'b11);
    hi_cmd = 3'b010; lo_cmd = 3'b001; aux_cmd = 0; cyc();
    chk("R2 second pattern", outs(), {1'b0, 3'b001, 3'b010});
  endtask

  task automatic t_ilk();
    ilk_en = 1; dead_cnt = 3;
    hi_cmd = 0; lo_cmd = 0; cyc(6);
    hi_cmd = 3'b111; lo_cmd = 3'b111; cyc();
    chk("R4 both requested gives neither", {lo_drv, hi_drv}, 6'd0);
    cyc(3);
    chk("R4 still neither", {lo_drv, hi_drv}, 6'd0);
    hi_cmd = 0; lo_cmd = 0; cyc(6);
  endtask

  task automatic t_dead(int d);
    ilk_en = 1; dead_cnt = 8'(d);
    hi_cmd = 0; lo_cmd = 0; cyc(10);
    hi_cmd = 3'b001; cyc();
    chk("R5 high on with no conflict", hi_drv, 3'b001);
    hi_cmd = 0; lo_cmd = 3'b001; cyc();
    chk("R5 high off on swap", {hi_drv[0], lo_drv[0]}, 2'b00);
    for (int k = 1; k <= d; k++) begin
      cyc();
      chk($sformatf("R5 dead gap d=%0d k=%0d", d, k), {hi_drv[0], lo_drv[0]}, 2'b00);
    end
    cyc();
    chk($sformatf("R5 low on after gap d=%0d", d), {hi_drv[0], lo_drv[0]}, 2'b01);
    lo_cmd = 0; cyc(d + 3);
  endtask

  task automatic t_uv();
    ilk_en = 0; hi_cmd = 3'b111; lo_cmd = 0; aux_cmd = 1; cyc();
    chk("R6 on before lockout", outs(), {1'b1, 3'b000, 3'b111});
    uv_set = 1; cyc();
    chk("R6 off on set", outs(), 7'd0);
    uv_set = 0; cyc();
    chk("R6 held by lockout", outs(), 7'd0);
    uv_set = 1; uv_rel = 1; cyc(); uv_set = 0; uv_rel = 0; cyc();
    chk("R6 set wins over release", outs(), 7'd0);
    chk("R6 no global error", err_out, 1'b0);
    uv_rel = 1; cyc(); uv_rel = 0;
    chk("R6 off on release edge", outs(), 7'd0);
    cyc();
    chk("R6 resumes after release", outs(), {1'b1, 3'b000, 3'b111});
  endtask

  task automatic t_oc();
    oc_flag = 4'b0010; cyc();
    chk("R7 local bit", loc_err, 4'b0010);
    chk("R7 global error", err_out, 1'b1);
    chk("R7 outputs off", outs(), 7'd0);
    clr = 1; cyc(); clr = 0;
    chk("R9 clear ignored with flag active", {loc_err, err_out}, 5'b00101);
    oc_flag = 0; cyc(3);
    chk("R8 error latched", {loc_err, err_out}, 5'b00101);
    chk("R8 outputs still off", outs(), 7'd0);
    oc_flag = 4'b1000; cyc(); oc_flag = 0;
    chk("R7 extra channel bit", loc_err, 4'b1010);
    clr = 1; cyc(); clr = 0;
    chk("R9 clear accepted", {loc_err, err_out}, 5'd0);
    chk("R9 off on clear edge", outs(), 7'd0);
    cyc();
    chk("R9 resume after clear", outs(), {1'b1, 3'b000, 3'b111});
    oc_flag = 4'b0001; cyc(); oc_flag = 0;
    uv_set = 1; cyc(); uv_set = 0;
    clr = 1; cyc(); clr = 0;
    chk("R9 clear ignored in lockout", err_out, 1'b1);
    uv_rel = 1; cyc(); uv_rel = 0;
    clr = 1; cyc(); clr = 0;
    chk("R9 clear after release", {loc_err, err_out}, 5'd0);
    cyc();
    chk("R9 outputs back", outs(), {1'b1, 3'b000, 3'b111});
  endtask

  initial begin
    t_reset();
    t_pass();
    t_ilk();
    t_dead(3);
    t_dead(0);
    t_uv();
    t_oc();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule